// File: doc/BRIEF.md
# Word-Time Gate Generator

This block produces a gate for serial datapaths that is high for exactly one word time, a fixed run of clock pulses (8 by default). A single-cycle request on the start input opens the gate on the next clock edge. While the gate is open it enables an internal binary counter. When that counter reaches its top value, the carry out of the counter closes the gate on the following edge. The counter wraps to zero at the same edge, so the block is ready for the next word at once.

Shift registers, serial adders and similar units use the gate as their shift enable, so that each transfer moves exactly one word. The running position within the word is also brought out, so that downstream logic can pick out particular bit times. A start request made while a word is already in progress is dropped. Word length is fixed at elaboration by the counter width.

Top module: `wordtime_gate`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `gate_o` to 0 and `count_o` to 0 after that edge, whatever `start_i` is.
- R2: With `gate_o` low, a high `start_i` at a clock edge sets `gate_o` to 1 after that edge, with `count_o` at 0.
- R3: Once opened, `gate_o` stays high for exactly 2**CNT_W consecutive clock cycles (8 for the default CNT_W = 3) and then goes low, unless a reset cuts the window short.
- R4: While `gate_o` is high, `count_o` rises by one at every edge. While `gate_o` is low, `count_o` holds at 0.
- R5: In the cycle where `gate_o` is high and `count_o` equals 2**CNT_W-1, the next edge drives `gate_o` low and wraps `count_o` to 0.
- R6: A high `start_i` while `gate_o` is already high has no effect: the window neither restarts nor stretches, and `count_o` keeps stepping.
- R7: When `start_i` is high in the last cycle of a window, the window still ends (stop has priority). The request is lost, and a start in the following cycle opens a new window after a one-cycle gap.
- R8: A reset in the middle of a window closes the gate and zeroes the count at once. A later start opens a full-length window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to open one word-time window |
| gate_o | output | 1 | Word-time gate, high for one full word |
| count_o | output | CNT_W | Bit position within the current word |

## Verification
The bench aims at the edges of the window. It checks the last count value, where a counter with an off-by-one stop would give a 7- or 9-cycle gate. It applies a start in the terminal cycle, where set-over-reset priority would keep the gate stuck high. It sends repeated starts mid-window, where a design that reloads the counter would stretch the word. It also holds start high for several words in a row, which shows the one-cycle gap between back-to-back windows. Finally, it resets halfway through a word. A design that cleared only the flip-flop there would begin the next word at a stale position.

// File: rtl/wt_pkg.sv
package wt_pkg;
   typedef enum logic [1:0] {
      CTL_HOLD = 2'd0,
      CTL_SET  = 2'd1,
      CTL_CLR  = 2'd2
   } ctl_op_e;

   function automatic ctl_op_e ctl_decide(input logic stop, input logic start);
      if (stop)       return CTL_CLR;
      else if (start) return CTL_SET;
      else            return CTL_HOLD;
   endfunction
endpackage

// File: rtl/wt_ctrl_ff.sv
module wt_ctrl_ff
   import wt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   ctl_op_e op;

   always_comb begin
      op = ctl_decide(clr_i, set_i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q_o <= 1'b0;
      end else begin
         unique case (op)
            CTL_CLR:  q_o <= 1'b0;
            CTL_SET:  q_o <= 1'b1;
            default:  q_o <= q_o;
         endcase
      end
   end
endmodule

// File: rtl/wt_carry_counter.sv
module wt_carry_counter #(
   parameter int unsigned WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   output logic [WIDTH-1:0] q_o,
   output logic             tc_o
);
   logic [WIDTH:0] carry;

   assign carry[0] = en_i;

   for (genvar b = 0; b < WIDTH; b++) begin : g_stage
      assign carry[b+1] = carry[b] & q_o[b];

      always_ff @(posedge clk) begin
         if (rst) q_o[b] <= 1'b0;
         else     q_o[b] <= q_o[b] ^ carry[b];
      end
   end

   assign tc_o = carry[WIDTH];
endmodule

// File: rtl/wordtime_gate.sv
module wordtime_gate #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   output logic             gate_o,
   output logic [CNT_W-1:0] count_o
);
   localparam int unsigned WORD_LEN = 1 << CNT_W;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
      $error("wordtime_gate: CNT_W must lie in 1..16");
   end
   if (WORD_LEN < 2) begin : g_bad_len
      $error("wordtime_gate: word length must be at least 2");
   end

   logic stop;

   wt_ctrl_ff u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .set_i (start_i),
      .clr_i (stop),
      .q_o   (gate_o)
   );

   wt_carry_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .en_i (gate_o),
      .q_o  (count_o),
      .tc_o (stop)
   );
endmodule

// File: rtl/wordtime_gate_chk.sv
module wordtime_gate_chk #(
   parameter int unsigned CNT_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic             gate_o,
   input logic [CNT_W-1:0] count_o
);
   localparam int unsigned WORD_LEN = 1 << CNT_W;
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W:0] run;

   always_ff @(posedge clk) begin
      if (rst)         run <= '0;
      else if (gate_o) run <= run + 1'b1;
      else             run <= '0;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!gate_o && count_o == '0));

   assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
      (!gate_o && start_i) |=> (gate_o && count_o == '0));

   assert_window_len_R3: assert property (@(posedge clk) disable iff (rst)
      (!gate_o && run != '0) |-> (run == (CNT_W+1)'(WORD_LEN)));

   assert_step_R4: assert property (@(posedge clk) disable iff (rst)
      (gate_o && count_o != TOP) |=> (gate_o && count_o == CNT_W'($past(count_o) + 1'b1)));

   assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
      !gate_o |-> (count_o == '0));

   assert_terminal_close_R5: assert property (@(posedge clk) disable iff (rst)
      (gate_o && count_o == TOP) |=> (!gate_o && count_o == '0));
endmodule

bind wordtime_gate wordtime_gate_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start_i (start_i),
   .gate_o  (gate_o),
   .count_o (count_o)
);

// File: tb/wordtime_gate_test.sv
module wordtime_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 3;
   localparam int WORD = 1 << CNT_W;

   typedef struct {
      int    due;
      logic  gate;
      int    cnt;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_i = 1'b0;
   logic gate_o;
   logic [CNT_W-1:0] count_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;
   exp_t sb[$];

   logic m_gate = 1'b0;
   int   m_cnt = 0;

   int  run_len = 0;
   bit  aborted = 0;

   wordtime_gate #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst(rst), .start_i(start_i),
      .gate_o(gate_o), .count_o(count_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare against scoreboard away from the active edge
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (gate_o !== e.gate || int'(count_o) != e.cnt) begin
            fails++;
            $display("FAIL %s: gate=%0d count=%0d expected gate=%0d count=%0d",
                     e.tag, gate_o, count_o, e.gate, e.cnt);
         end
      end
   end

   // window-length monitor (R3)
   always @(negedge clk) begin
      if (rst) aborted = (run_len != 0) || aborted;
      if (gate_o === 1'b1) begin
         run_len++;
      end else begin
         if (run_len != 0 && !aborted) begin
            checks++;
            if (run_len != WORD) begin
               fails++;
               $display("FAIL R3: window length=%0d expected=%0d", run_len, WORD);
            end
         end
         run_len = 0;
         aborted = 0;
      end
   end

   task automatic step(input logic s, input logic r, input string tag);
      @(negedge clk);
      start_i = s;
      rst = r;
      if (r) begin
         m_gate = 1'b0; m_cnt = 0;
      end else if (m_gate) begin
         if (m_cnt == WORD-1) begin m_gate = 1'b0; m_cnt = 0; end
         else m_cnt = m_cnt + 1;
      end else if (s) begin
         m_gate = 1'b1; m_cnt = 0;
      end
      sb.push_back('{due: cyc + 1, gate: m_gate, cnt: m_cnt, tag: tag});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, got hung expected done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state, start ignored during reset
      step(1'b0, 1'b1, "R1");
      step(1'b1, 1'b1, "R1");
      // R4: idle holds zero
      repeat (3) step(1'b0, 1'b0, "R4");
      // R2, R4, R5: single word
      step(1'b1, 1'b0, "R2");
      repeat (WORD + 2) step(1'b0, 1'b0, "R5");
      // R6: starts mid-window ignored
      step(1'b1, 1'b0, "R2");
      step(1'b0, 1'b0, "R4");
      step(1'b0, 1'b0, "R4");
      step(1'b1, 1'b0, "R6");
      step(1'b1, 1'b0, "R6");
      repeat (WORD) step(1'b0, 1'b0, "R6");
      // R7: start exactly on terminal cycle, then relaunch
      step(1'b1, 1'b0, "R2");
      repeat (WORD - 1) step(1'b0, 1'b0, "R4");
      step(1'b1, 1'b0, "R7");
      step(1'b1, 1'b0, "R7");
      repeat (WORD + 2) step(1'b0, 1'b0, "R7");
      // R7: start held high across several words
      repeat (3 * WORD + 4) step(1'b1, 1'b0, "R7");
      repeat (2) step(1'b0, 1'b0, "R7");
      // R8: reset mid-window with start high, then full window
      step(1'b1, 1'b0, "R2");
      repeat (4) step(1'b0, 1'b0, "R4");
      step(1'b1, 1'b1, "R8");
      step(1'b0, 1'b0, "R8");
      step(1'b1, 1'b0, "R8");
      repeat (WORD + 2) step(1'b0, 1'b0, "R8");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule